// File: doc/BRIEF.md
# Processor status word controller

This block holds the processor status word and the state its fields steer: the four condition flags, the trace flag, a three-bit interrupt priority, a one-bit general-register set select, and two-bit current and previous privilege modes. The status word can be reloaded from three sources, each with its own privilege rule. A return from interrupt or trap is privileged only in kernel mode. A trap vector entry is privileged. A bus write to the status word is privileged, but the current mode is first ORed into the previous-mode field, so software cannot lower its own mode through that path. An unprivileged load can only add bits to the mode and register-set fields.

Alongside the status word the block keeps one banked stack pointer per privilege mode and two banks of six general registers. When the current mode changes, the live stack pointer is saved into the bank of the old mode and reloaded from the bank of the new mode. The register-set bit chooses which general-register bank the read and write ports reach. The assembled status word and the current mode are outputs, and the current mode goes to the address translation unit.

Top module: `psw_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word, stack pointer, all stack-pointer banks, all general registers and the read data are cleared to zero.
- R2: `psw` carries C in bit 0, V in bit 1, Z in bit 2, N in bit 3, T in bit 4, priority in bits 7:5, register set in bit 11, previous mode in bits 13:12 and current mode in bits 15:14. Bits 10:8 read as zero. `cur_mode` equals bits 15:14.
- R3: A privileged load replaces the priority, register-set, previous-mode and current-mode fields with the loaded bits.
- R4: An unprivileged load ORs the loaded register-set, previous-mode and current-mode bits into the held values and keeps the priority.
- R5: Every load takes bits 4:0 (condition flags and T) from the loaded value, whatever the privilege.
- R6: A return load (`ld_rti`) is privileged only when the current mode is 0.
- R7: A trap entry (`ld_trap`) and a bus write (`ld_bus`) OR the current mode into loaded bits 13:12 and then load with privilege. A bus write thereby also selects the register set given by its bit 11.
- R8: A resulting current mode of 2 is stored as 3, so `cur_mode` never reads 2.
- R9: When the current mode changes, the live stack pointer is saved into the old mode's bank and `sp` is reloaded from the new mode's bank. A stack-pointer write in the same cycle goes to the old mode's bank. Without a mode change, a write updates `sp` directly, and with no write and no load `sp` holds.
- R10: General-register reads and writes reach registers 0 to 5 in the bank named by the register-set bit held before the clock edge. Changing the set swaps all six at once and leaves `sp` unchanged.
- R11: When several loads are requested in one cycle, a trap entry wins over a return, and a return wins over a bus write.
- R12: `gpr_rd_data` shows the register addressed one clock earlier. Addresses 6 and 7 are not stored: writes to them are dropped and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_rti | input | 1 | Load status word from a return from interrupt or trap |
| ld_trap | input | 1 | Load status word from a trap vector entry |
| ld_bus | input | 1 | Load status word from a bus write |
| ld_value | input | 16 | Value to load |
| sp_wr_en | input | 1 | Write the live stack pointer |
| sp_wr_data | input | DW | Stack pointer write data |
| gpr_wr_en | input | 1 | General register write enable |
| gpr_wr_addr | input | RA_W | General register write address |
| gpr_wr_data | input | DW | General register write data |
| gpr_rd_addr | input | RA_W | General register read address |
| psw | output | 16 | Assembled status word |
| cur_mode | output | 2 | Current privilege mode for address translation |
| sp | output | DW | Live stack pointer |
| gpr_rd_data | output | DW | Registered general register read data |

## Verification
A status load that changes the current mode can arrive in the same cycle as a stack-pointer write. A load that flips the register set can arrive together with a general-register write and read. The bench provokes both on purpose with directed steps and also lets them meet by chance in a long seeded random run. A bench model judges each case: the write must land in the old mode's stack bank or the old register bank, and the live pointer must come from the new mode's bank. Competing load sources in one cycle are checked in the same way against the stated order.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W = 16;

  typedef logic [1:0] mode_t;

  typedef struct packed {
    mode_t      cur;
    mode_t      prv;
    logic       rs;
    logic [2:0] pri;
    logic       t;
    logic       n;
    logic       z;
    logic       v;
    logic       c;
  } psw_state_t;

  function automatic mode_t fold_mode(mode_t m);
    return (m == 2'd2) ? 2'd3 : m;
  endfunction

  function automatic logic [PSW_W-1:0] pack_psw(psw_state_t s);
    return {s.cur, s.prv, s.rs, 3'b000, s.pri, s.t, s.n, s.z, s.v, s.c};
  endfunction
endpackage

// File: rtl/psw_load_unit.sv
module psw_load_unit
  import psw_pkg::*;
(
  input  psw_state_t       cur_q,
  input  logic             ld_rti,
  input  logic             ld_trap,
  input  logic             ld_bus,
  input  logic [PSW_W-1:0] ld_value,
  output logic             load_any,
  output psw_state_t       nxt
);
  logic [PSW_W-1:0] word;
  logic             priv;

  // Source arbitration: trap entry, then return, then bus write.
  always_comb begin
    load_any = ld_trap | ld_rti | ld_bus;
    if (ld_trap) begin
      word = ld_value | {2'b00, cur_q.cur, 12'h000};
      priv = 1'b1;
    end else if (ld_rti) begin
      word = ld_value;
      priv = (cur_q.cur == 2'd0);
    end else begin
      word = ld_value | {2'b00, cur_q.cur, 12'h000};
      priv = 1'b1;
    end
  end

  always_comb begin
    nxt   = cur_q;
    nxt.c = word[0];
    nxt.v = word[1];
    nxt.z = word[2];
    nxt.n = word[3];
    nxt.t = word[4];
    if (priv) begin
      nxt.pri = word[7:5];
      nxt.rs  = word[11];
      nxt.prv = word[13:12];
      nxt.cur = fold_mode(word[15:14]);
    end else begin
      nxt.rs  = cur_q.rs | word[11];
      nxt.prv = cur_q.prv | word[13:12];
      nxt.cur = fold_mode(cur_q.cur | word[15:14]);
    end
  end
endmodule

// File: rtl/psw_sp_bank.sv
module psw_sp_bank
  import psw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_t         old_mode,
  input  mode_t         new_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] sp
);
  localparam int NMODES = 4;

  logic [DW-1:0] shadow [NMODES];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
      for (int i = 0; i < NMODES; i++) shadow[i] <= '0;
    end else if (new_mode != old_mode) begin
      shadow[old_mode] <= wr_en ? wr_data : sp;
      sp               <= shadow[new_mode];
    end else if (wr_en) begin
      sp <= wr_data;
    end
  end
endmodule

// File: rtl/psw_gpr_bank.sv
module psw_gpr_bank #(
  parameter int DW    = 16,
  parameter int NREG  = 6,
  parameter int NSETS = 2,
  parameter int RA_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_sel,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [RA_W-1:0] rd_addr,
  output logic [DW-1:0]   rd_data
);
  localparam int DEPTH = NSETS * NREG;
  localparam int IW    = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] widx;
  logic [IW-1:0] ridx;
  logic          wr_ok;
  logic          rd_ok;

  always_comb begin
    widx  = IW'(int'(set_sel) * NREG + int'(wr_addr));
    ridx  = IW'(int'(set_sel) * NREG + int'(rd_addr));
    wr_ok = wr_en && (int'(wr_addr) < NREG);
    rd_ok = (int'(rd_addr) < NREG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_ok) mem[widx] <= wr_data;
      rd_data <= rd_ok ? mem[ridx] : '0;
    end
  end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 6,
  parameter int RA_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_rti,
  input  logic             ld_trap,
  input  logic             ld_bus,
  input  logic [PSW_W-1:0] ld_value,
  input  logic             sp_wr_en,
  input  logic [DW-1:0]    sp_wr_data,
  input  logic             gpr_wr_en,
  input  logic [RA_W-1:0]  gpr_wr_addr,
  input  logic [DW-1:0]    gpr_wr_data,
  input  logic [RA_W-1:0]  gpr_rd_addr,
  output logic [PSW_W-1:0] psw,
  output logic [1:0]       cur_mode,
  output logic [DW-1:0]    sp,
  output logic [DW-1:0]    gpr_rd_data
);
  localparam int NSETS = 2;

  psw_state_t state_q;
  psw_state_t state_d;
  logic       load_any;
  mode_t      mode_next;

  psw_load_unit u_load (
    .cur_q    (state_q),
    .ld_rti   (ld_rti),
    .ld_trap  (ld_trap),
    .ld_bus   (ld_bus),
    .ld_value (ld_value),
    .load_any (load_any),
    .nxt      (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else if (load_any) state_q <= state_d;
  end

  assign mode_next = load_any ? state_d.cur : state_q.cur;

  psw_sp_bank #(.DW(DW)) u_sp (
    .clk      (clk),
    .rst      (rst),
    .old_mode (state_q.cur),
    .new_mode (mode_next),
    .wr_en    (sp_wr_en),
    .wr_data  (sp_wr_data),
    .sp       (sp)
  );

  psw_gpr_bank #(.DW(DW), .NREG(NREG), .NSETS(NSETS), .RA_W(RA_W)) u_gpr (
    .clk     (clk),
    .rst     (rst),
    .set_sel (state_q.rs),
    .wr_en   (gpr_wr_en),
    .wr_addr (gpr_wr_addr),
    .wr_data (gpr_wr_data),
    .rd_addr (gpr_rd_addr),
    .rd_data (gpr_rd_data)
  );

  assign psw      = pack_psw(state_q);
  assign cur_mode = state_q.cur;
endmodule

// File: rtl/psw_ctrl_chk.sv
module psw_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_rti,
  input logic          ld_trap,
  input logic          ld_bus,
  input logic [15:0]   ld_value,
  input logic          sp_wr_en,
  input logic [15:0]   psw,
  input logic [1:0]    cur_mode,
  input logic [DW-1:0] sp
);
  logic any_ld;
  assign any_ld = ld_rti | ld_trap | ld_bus;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (psw == 16'h0) && (sp == '0));

  assert_flags_taken_R5: assert property (@(posedge clk) disable iff (rst)
    any_ld |=> psw[4:0] == $past(ld_value[4:0]));

  assert_unpriv_keeps_pri_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_rti && !ld_trap && psw[15:14] != 2'd0) |=> psw[7:5] == $past(psw[7:5]));

  assert_prev_gets_mode_R7: assert property (@(posedge clk) disable iff (rst)
    ld_trap |=> psw[13:12] == ($past(ld_value[13:12]) | $past(psw[15:14])));

  assert_no_mode_two_R8: assert property (@(posedge clk) disable iff (rst)
    cur_mode != 2'd2);

  assert_mode_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !any_ld |=> $stable(cur_mode));

  assert_sp_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!any_ld && !sp_wr_en) |=> $stable(sp));
endmodule

bind psw_ctrl psw_ctrl_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_rti   (ld_rti),
  .ld_trap  (ld_trap),
  .ld_bus   (ld_bus),
  .ld_value (ld_value),
  .sp_wr_en (sp_wr_en),
  .psw      (psw),
  .cur_mode (cur_mode),
  .sp       (sp)
);

// File: tb/psw_ctrl_test.sv
module psw_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_rti = 0, ld_trap = 0, ld_bus = 0;
  logic [15:0] ld_value = '0;
  logic sp_wr_en = 0;
  logic [DW-1:0] sp_wr_data = '0;
  logic gpr_wr_en = 0;
  logic [2:0] gpr_wr_addr = '0;
  logic [DW-1:0] gpr_wr_data = '0;
  logic [2:0] gpr_rd_addr = '0;
  logic [15:0] psw;
  logic [1:0] cur_mode;
  logic [DW-1:0] sp;
  logic [DW-1:0] gpr_rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0]   m_psw;
  logic [DW-1:0] m_sp;
  logic [DW-1:0] m_rd;
  logic [DW-1:0] m_shadow [4];
  logic [DW-1:0] m_gpr [2][6];

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_ctrl uut (
    .clk(clk), .rst(rst), .ld_rti(ld_rti), .ld_trap(ld_trap), .ld_bus(ld_bus),
    .ld_value(ld_value), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .gpr_wr_en(gpr_wr_en), .gpr_wr_addr(gpr_wr_addr), .gpr_wr_data(gpr_wr_data),
    .gpr_rd_addr(gpr_rd_addr), .psw(psw), .cur_mode(cur_mode), .sp(sp),
    .gpr_rd_data(gpr_rd_data)
  );

  function automatic logic [1:0] fm(logic [1:0] m);
    return (m == 2'd2) ? 2'd3 : m;
  endfunction

  function automatic logic [15:0] f_next(logic [15:0] p, bit tr, bit rt, bit bu, logic [15:0] v);
    logic [15:0] w;
    logic [15:0] r;
    bit pr;
    if (!(tr || rt || bu)) return p;
    if (tr || !rt) begin w = v | {2'b00, p[15:14], 12'h000}; pr = 1; end
    else begin w = v; pr = (p[15:14] == 2'd0); end
    r = 16'h0;
    r[4:0] = w[4:0];
    if (pr) begin
      r[7:5] = w[7:5]; r[11] = w[11]; r[13:12] = w[13:12]; r[15:14] = fm(w[15:14]);
    end else begin
      r[7:5] = p[7:5]; r[11] = p[11] | w[11]; r[13:12] = p[13:12] | w[13:12];
      r[15:14] = fm(p[15:14] | w[15:14]);
    end
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "psw", 32'(psw), 32'(m_psw));
    chk(tag, "cur_mode", 32'(cur_mode), 32'(m_psw[15:14]));
    chk(tag, "sp", 32'(sp), 32'(m_sp));
    chk(tag, "gpr_rd_data", 32'(gpr_rd_data), 32'(m_rd));
  endtask

  task automatic model_reset();
    m_psw = '0; m_sp = '0; m_rd = '0;
    for (int i = 0; i < 4; i++) m_shadow[i] = '0;
    for (int s = 0; s < 2; s++) for (int i = 0; i < 6; i++) m_gpr[s][i] = '0;
  endtask

  task automatic step(bit tr, bit rt, bit bu, logic [15:0] v, bit spw, logic [DW-1:0] spd,
                      bit gw, logic [2:0] ga, logic [DW-1:0] gd, logic [2:0] ra);
    logic [15:0] np;
    logic [1:0] om, nm;
    logic [DW-1:0] rdn;
    @(negedge clk);
    ld_trap = tr; ld_rti = rt; ld_bus = bu; ld_value = v;
    sp_wr_en = spw; sp_wr_data = spd;
    gpr_wr_en = gw; gpr_wr_addr = ga; gpr_wr_data = gd; gpr_rd_addr = ra;
    np = f_next(m_psw, tr, rt, bu, v);
    om = m_psw[15:14]; nm = np[15:14];
    rdn = (ra < 3'd6) ? m_gpr[m_psw[11]][ra] : '0;
    if (gw && ga < 3'd6) m_gpr[m_psw[11]][ga] = gd;
    if (nm != om) begin
      m_shadow[om] = spw ? spd : m_sp;
      m_sp = m_shadow[nm];
    end else if (spw) m_sp = spd;
    m_psw = np;
    m_rd = rdn;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 16'h0, 0, '0, 0, 3'd0, '0, 3'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    model_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2 R5: privileged trap from kernel loads flags and T
    step(1, 0, 0, 16'h001F, 0, '0, 0, 3'd0, '0, 3'd0);
    check_all("R2");
    chk("R5", "flags", 32'(psw[4:0]), 32'h1F);
    // sp write in mode 0
    step(0, 0, 0, 16'h0, 1, 16'h1000, 0, 3'd0, '0, 3'd0);
    check_all("R9");
    // R3 R7: bus write raises to mode 3, prev gets old mode OR value
    step(0, 0, 1, 16'hC0E5, 1, 16'h2222, 0, 3'd0, '0, 3'd0);
    check_all("R7");
    chk("R3", "pri", 32'(psw[7:5]), 32'h7);
    chk("R9", "sp from new bank", 32'(sp), 32'h0);
    step(0, 0, 0, 16'h0, 1, 16'h3000, 0, 3'd0, '0, 3'd0);
    // R4 R6: return from mode 3 is unprivileged
    step(0, 1, 0, 16'h0010, 0, '0, 0, 3'd0, '0, 3'd0);
    check_all("R6");
    chk("R4", "pri kept", 32'(psw[7:5]), 32'h7);
    chk("R4", "mode kept", 32'(cur_mode), 32'h3);
    // trap to kernel: prev = 3, sp back to kernel bank
    step(1, 0, 0, 16'h0000, 0, '0, 0, 3'd0, '0, 3'd0);
    check_all("R9");
    chk("R9", "kernel sp restored", 32'(sp), 32'h2222);
    // R8: privileged return requesting mode 2
    step(0, 1, 0, 16'h8000, 0, '0, 0, 3'd0, '0, 3'd0);
    check_all("R8");
    chk("R8", "mode folded", 32'(cur_mode), 32'h3);
    chk("R9", "mode3 sp", 32'(sp), 32'h3000);
    step(1, 0, 0, 16'h0000, 0, '0, 0, 3'd0, '0, 3'd0);
    // R10 R12: register banks
    step(0, 0, 0, 16'h0, 0, '0, 1, 3'd2, 16'hAAAA, 3'd0);
    step(0, 0, 1, 16'h0800, 0, '0, 0, 3'd0, '0, 3'd2);
    check_all("R12");
    step(0, 0, 0, 16'h0, 0, '0, 1, 3'd2, 16'h5555, 3'd2);
    step(0, 0, 0, 16'h0, 0, '0, 1, 3'd7, 16'h7777, 3'd2);
    check_all("R10");
    chk("R10", "set1 r2", 32'(gpr_rd_data), 32'h5555);
    step(0, 0, 1, 16'h0000, 0, '0, 0, 3'd0, '0, 3'd7);
    chk("R12", "addr7 reads zero", 32'(gpr_rd_data), 32'h0);
    step(0, 0, 0, 16'h0, 0, '0, 0, 3'd0, '0, 3'd2);
    check_all("R10");
    chk("R10", "set0 r2", 32'(gpr_rd_data), 32'hAAAA);
    // R11: all three sources together
    step(1, 1, 1, 16'h40A3, 0, '0, 0, 3'd0, '0, 3'd0);
    check_all("R11");
    step(0, 1, 1, 16'h0800, 0, '0, 0, 3'd0, '0, 3'd0);
    check_all("R11");
    idle();
    check_all("R9");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] == 0, r[7:4] == 0, r[11:8] == 0, 16'($urandom),
           r[12], 16'($urandom), r[13], 3'($urandom), 16'($urandom), 3'($urandom));
      check_all("RAND");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule